// File: doc/BRIEF.md
# Timer Interrupt Status and Line Router

This block sits between a bank of timer channels and the interrupt controller inputs. Each channel reports expiry as a one-cycle strobe. Level-type channels keep a status bit that software clears by writing ones. Edge-type channels produce a single-cycle pulse. Each channel drives one of `NLINES` interrupt lines. A route field chosen per channel selects the line. Several channels that share a line are OR-combined.

A legacy replacement mode pins channel 0 to line `LINE_A` (default 0) and channel 1 to line `LINE_B` (default 8). In that mode two external legacy sources are blocked. When the mode is off, an external periodic-timer input reaches line `LINE_A` and a latched real-time-clock input reaches line `LINE_B`. A side-band enable output tells the external periodic timer whether it owns its line. Interrupt delivery also needs both the channel enable and the global enable.

Top module: `tir_irq_router`

## Requirements
- R1: An expiry strobe on a channel whose level bit (`ch_level[i]`=1) is set makes `status[i]` 1 on the next clock edge.
- R2: A status bit is cleared on the next edge whenever its channel is edge-type (`ch_level[i]`=0). This covers an edge-type expiry and a level-to-edge reconfiguration. The channel's line contribution drops in the same cycle the level bit falls.
- R3: A channel drives its line only while `ch_enable[i]` and `glb_en` are both 1. A level channel holds the line while its status bit is set. An edge channel raises the line for exactly the one cycle after its expiry edge.
- R4: A cycle with `sts_clr_wr`=1 clears every status bit whose `sts_clr_data` bit is 1. Bits written 0 keep their value. An expiry in the same cycle wins over the clear.
- R5: Outside legacy mode, channel i drives `irq[route_flat[i*RW +: RW]]`, where RW = $clog2(NLINES). Channels sharing a line are OR-combined.
- R6: With `legacy_mode`=1, channel 0 drives `irq[LINE_A]` and channel 1 drives `irq[LINE_B]` whatever their route fields hold. Other channels keep their route fields.
- R7: With `legacy_mode`=0, `pit_in` reaches `irq[LINE_A]` in the same cycle, and the `rtc_in` level sampled at the previous edge reaches `irq[LINE_B]`. With `legacy_mode`=1 both are blocked. `pit_enable` equals the inverse of `legacy_mode`.
- R8: The RTC input is sampled every cycle, legacy mode or not. On leaving legacy mode, `irq[LINE_B]` at once shows the most recent sample.
- R9: While `glb_en`=0, status bits keep their values and all channel contributions are low. When `glb_en` or a channel enable rises with a status bit set, the level line is raised in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global interrupt delivery enable |
| legacy_mode | input | 1 | Legacy replacement routing select |
| ch_level | input | NCH | Per-channel level-type select (1 = level, 0 = edge) |
| ch_enable | input | NCH | Per-channel interrupt enable |
| route_flat | input | NCH*RW | Packed per-channel line selects, channel i at [i*RW +: RW] |
| expire | input | NCH | Per-channel expiry strobes |
| sts_clr_wr | input | 1 | Status write-one-to-clear strobe |
| sts_clr_data | input | NCH | Write-one-to-clear mask |
| pit_in | input | 1 | External periodic-timer interrupt input |
| rtc_in | input | 1 | External real-time-clock interrupt level |
| irq | output | NLINES | Interrupt output lines |
| status | output | NCH | Per-channel interrupt status |
| pit_enable | output | 1 | External periodic-timer ownership enable |

## Verification
The bench drives level channels and edge channels onto separate lines. This tells a held status line apart from a one-cycle pulse. Two level channels share one line while only one of them is cleared, which shows whether the lines are OR-combined or driven by the last writer. Clear masks with zero bits on set channels, and clears in the same cycle as an expiry, show the write-one-to-clear rule and its priority. Toggling the enables, the legacy mode and the RTC level in different orders shows which gating is combinational and which state survives.

// File: rtl/tir_pkg.sv
package tir_pkg;

  // Destination line of one channel: legacy mode pins channels 0 and 1.
  function automatic int unsigned tir_dest(input int unsigned ch,
                                           input logic legacy,
                                           input int unsigned route,
                                           input int unsigned line_a,
                                           input int unsigned line_b);
    if (legacy && ch == 0) return line_a;
    if (legacy && ch == 1) return line_b;
    return route;
  endfunction

  // Next status bit: only a level channel can hold it; expiry beats a clear.
  function automatic logic tir_status_next(input logic lvl, input logic exp_s,
                                           input logic cur, input logic clr);
    return lvl & (exp_s | (cur & ~clr));
  endfunction

endpackage

// File: rtl/tir_status.sv
module tir_status #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           glb_en,
  input  logic [NCH-1:0] ch_level,
  input  logic [NCH-1:0] ch_enable,
  input  logic [NCH-1:0] expire,
  input  logic           clr_wr,
  input  logic [NCH-1:0] clr_data,
  output logic [NCH-1:0] status_q,
  output logic [NCH-1:0] contrib
);
  logic [NCH-1:0] pulse_q;
  logic [NCH-1:0] clr_mask;
  logic [NCH-1:0] expire_lvl;
  logic [NCH-1:0] expire_edge;

  assign clr_mask    = clr_wr ? clr_data : '0;
  assign expire_lvl  = expire & ch_level;
  assign expire_edge = expire & ~ch_level;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        status_q[c] <= 1'b0;
        pulse_q[c]  <= 1'b0;
      end else begin
        status_q[c] <= tir_pkg::tir_status_next(ch_level[c], expire[c],
                                                status_q[c], clr_mask[c]);
        pulse_q[c]  <= expire_edge[c];
      end
    end
    assign contrib[c] = glb_en & ch_enable[c] &
                        (ch_level[c] ? status_q[c] : pulse_q[c]);
  end

  // R1
  lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_lvl != '0) |=> ((status_q & $past(expire_lvl)) == $past(expire_lvl)));

  // R2
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(ch_level)) == '0));

  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((status_q & $past(clr_data & ~expire)) == '0));

  // R3
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0) |=> ((pulse_q & $past(pulse_q) & ~$past(expire)) == '0));

endmodule

// File: rtl/tir_route.sv
module tir_route #(
  parameter int NCH    = 32,
  parameter int NLINES = 32,
  parameter int LINE_A = 0,
  parameter int LINE_B = 8,
  localparam int RW    = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legacy,
  input  logic [NCH-1:0]    contrib,
  input  logic [NCH*RW-1:0] route_flat,
  output logic [NLINES-1:0] lines
);
  int unsigned dest [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_dest
    assign dest[c] = tir_pkg::tir_dest(c, legacy, 32'(route_flat[c*RW +: RW]),
                                       LINE_A, LINE_B);
  end

  always_comb begin
    lines = '0;
    for (int c = 0; c < NCH; c++) begin
      if (dest[c] < NLINES) lines[RW'(dest[c])] = lines[RW'(dest[c])] | contrib[c];
    end
  end

  // R6
  legacy_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy && contrib[0]) |-> (lines[LINE_A] && ((contrib[1] == 1'b0) || lines[LINE_B])));

endmodule

// File: rtl/tir_legacy.sv
module tir_legacy (
  input  logic clk,
  input  logic rst_n,
  input  logic legacy,
  input  logic pit_in,
  input  logic rtc_in,
  output logic pass_a,
  output logic pass_b,
  output logic pit_enable
);
  logic rtc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rtc_q <= 1'b0;
    else        rtc_q <= rtc_in;
  end

  assign pass_a     = pit_in & ~legacy;
  assign pass_b     = rtc_q & ~legacy;
  assign pit_enable = ~legacy;
endmodule

// File: rtl/tir_irq_router.sv
module tir_irq_router #(
  parameter int NCH    = 32,
  parameter int NLINES = 32,
  parameter int LINE_A = 0,
  parameter int LINE_B = 8,
  localparam int RW    = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              legacy_mode,
  input  logic [NCH-1:0]    ch_level,
  input  logic [NCH-1:0]    ch_enable,
  input  logic [NCH*RW-1:0] route_flat,
  input  logic [NCH-1:0]    expire,
  input  logic              sts_clr_wr,
  input  logic [NCH-1:0]    sts_clr_data,
  input  logic              pit_in,
  input  logic              rtc_in,
  output logic [NLINES-1:0] irq,
  output logic [NCH-1:0]    status,
  output logic              pit_enable
);
  logic [NCH-1:0]    contrib;
  logic [NLINES-1:0] ch_lines;
  logic              pass_a;
  logic              pass_b;

  tir_status #(.NCH(NCH)) u_status (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ch_level(ch_level),
    .ch_enable(ch_enable), .expire(expire), .clr_wr(sts_clr_wr),
    .clr_data(sts_clr_data), .status_q(status), .contrib(contrib)
  );

  tir_route #(.NCH(NCH), .NLINES(NLINES), .LINE_A(LINE_A), .LINE_B(LINE_B)) u_route (
    .clk(clk), .rst_n(rst_n), .legacy(legacy_mode), .contrib(contrib),
    .route_flat(route_flat), .lines(ch_lines)
  );

  tir_legacy u_legacy (
    .clk(clk), .rst_n(rst_n), .legacy(legacy_mode), .pit_in(pit_in),
    .rtc_in(rtc_in), .pass_a(pass_a), .pass_b(pass_b), .pit_enable(pit_enable)
  );

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    if (l == LINE_A)      begin : g_a assign irq[l] = ch_lines[l] | pass_a; end
    else if (l == LINE_B) begin : g_b assign irq[l] = ch_lines[l] | pass_b; end
    else                  begin : g_n assign irq[l] = ch_lines[l]; end
  end

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && legacy_mode) |-> (irq == '0));

endmodule

// File: tb/tir_irq_router_tb.sv
`timescale 1ns/1ps
module tir_irq_router_tb;
  localparam int NCH = 32, NLINES = 32, RW = 5, LA = 0, LB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              glb_en = 0, legacy_mode = 0, sts_clr_wr = 0, pit_in = 0, rtc_in = 0;
  logic [NCH-1:0]    ch_level = '0, ch_enable = '0, expire = '0, sts_clr_data = '0;
  logic [NCH*RW-1:0] route_flat = '0;
  logic [NLINES-1:0] irq;
  logic [NCH-1:0]    status;
  logic              pit_enable;

  tir_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_mode(legacy_mode),
    .ch_level(ch_level), .ch_enable(ch_enable), .route_flat(route_flat),
    .expire(expire), .sts_clr_wr(sts_clr_wr), .sts_clr_data(sts_clr_data),
    .pit_in(pit_in), .rtc_in(rtc_in), .irq(irq), .status(status), .pit_enable(pit_enable)
  );

  // bench model state
  logic [NCH-1:0] m_sts = '0, m_pulse = '0;
  logic           m_rtc = 1'b0;

  // scoreboard queues
  logic [NLINES-1:0] q_irq [$];
  logic [NCH-1:0]    q_sts [$];
  logic              q_pe  [$];
  string             q_tag [$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int line_of(input int ch);
    if (legacy_mode == 1'b1 && ch < 2) return (ch == 0) ? LA : LB;
    return int'(route_flat[ch*RW +: RW]);
  endfunction

  function automatic logic [NLINES-1:0] model_irq();
    logic [NLINES-1:0] v = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      logic on;
      on = glb_en && ch_enable[ch] && (ch_level[ch] ? m_sts[ch] : m_pulse[ch]);
      if (on) v[line_of(ch)] = 1'b1;
    end
    if (!legacy_mode) begin
      if (pit_in) v[LA] = 1'b1;
      if (m_rtc)  v[LB] = 1'b1;
    end
    return v;
  endfunction

  // driver: push expected outputs, then let one edge pass and advance the model
  task automatic step(input string tag);
    q_irq.push_back(model_irq());
    q_sts.push_back(m_sts);
    q_pe.push_back(!legacy_mode);
    q_tag.push_back(tag);
    @(posedge clk);
    for (int ch = 0; ch < NCH; ch++) begin
      if (!ch_level[ch])    m_sts[ch] = 1'b0;
      else if (expire[ch])  m_sts[ch] = 1'b1;
      else if (sts_clr_wr && sts_clr_data[ch]) m_sts[ch] = 1'b0;
      m_pulse[ch] = expire[ch] && !ch_level[ch];
    end
    m_rtc = rtc_in;
    #1;
  endtask

  // monitor
  always @(negedge clk) begin
    while (q_irq.size() > 0) begin
      logic [NLINES-1:0] ei;
      logic [NCH-1:0]    es;
      logic              ep;
      string             t;
      ei = q_irq.pop_front(); es = q_sts.pop_front(); ep = q_pe.pop_front(); t = q_tag.pop_front();
      checks++;
      if (irq !== ei || status !== es || pit_enable !== ep) begin
        errors++;
        $display("FAIL %s irq=%h/%h status=%h/%h pit_enable=%b/%b (actual/expected)",
                 t, irq, ei, status, es, pit_enable, ep);
      end
    end
  end

  task automatic set_route(input int ch, input int line);
    route_flat[ch*RW +: RW] = RW'(line);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step("R3 reset state");
    glb_en = 1; ch_enable = '1;
    set_route(2, 5); set_route(3, 5); set_route(4, 12); set_route(0, 20); set_route(1, 21);
    ch_level[2] = 1;
    step("R5 idle after config");
    expire[2] = 1; step("R1 level expiry");
    expire = '0;   step("R1 status held, line 5 high");
    step("R3 level line held");
    expire[4] = 1; step("R3 edge expiry");
    expire = '0;   step("R3 edge pulse on line 12");
    step("R3 edge pulse gone");
    sts_clr_wr = 1; sts_clr_data = 32'h8; step("R4 zero bit on set channel");
    sts_clr_data = 32'h4; step("R4 clear set bit");
    sts_clr_wr = 0; sts_clr_data = '0; step("R4 line lowered");
    ch_level[3] = 1; expire[2] = 1; expire[3] = 1; step("R5 two on line 5");
    expire = '0; sts_clr_wr = 1; sts_clr_data = 32'h4; step("R5 clear one");
    sts_clr_wr = 0; sts_clr_data = '0; step("R5 OR keeps line 5");
    expire[3] = 1; sts_clr_wr = 1; sts_clr_data = 32'h8; step("R4 expiry beats clear");
    expire = '0; sts_clr_wr = 0; sts_clr_data = '0; step("R4 expiry won");
    glb_en = 0; step("R9 global off, status kept");
    step("R9 global off hold");
    glb_en = 1; step("R9 global on reasserts");
    ch_enable[3] = 0; step("R3 channel disabled");
    ch_enable[3] = 1; step("R9 channel enable reasserts");
    ch_level[3] = 0; step("R2 level cleared drops line");
    step("R2 status cleared");
    expire[4] = 1; ch_enable[4] = 0; step("R3 disabled edge expiry");
    expire = '0; step("R3 no pulse when disabled");
    ch_enable[4] = 1;
    pit_in = 1; step("R7 pit pass");
    pit_in = 0; rtc_in = 1; step("R7 rtc not yet latched");
    step("R7 rtc latched");
    legacy_mode = 1; pit_in = 1; step("R7 legacy blocks");
    ch_level[0] = 1; ch_level[1] = 1; expire[0] = 1; expire[1] = 1; step("R6 legacy expiry");
    expire = '0; step("R6 channels 0/1 pinned");
    rtc_in = 0; step("R8 rtc sampled in legacy");
    rtc_in = 1; step("R8 rtc sampled again");
    glb_en = 0; step("R9 quiet in legacy");
    glb_en = 1; ch_level[0] = 0; ch_level[1] = 0; pit_in = 0;
    step("R2 legacy channels to edge");
    legacy_mode = 0; step("R8 leave legacy shows latched rtc");
    rtc_in = 0; step("R8 rtc drop latch");
    step("R7 rtc low");
    @(negedge clk); #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule